// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block decides, on every clock, whether one of N interrupt lines should be taken now, either from an idle processor or by preempting the handler that is already running. Each line has a pending input, an enable input and a 4-bit priority held in a configuration register. A numerically smaller priority is more urgent, and 0 is the most urgent. A 3-bit split field, set at run time, divides the 4 priority bits into a group part and a sub part. The group part alone decides preemption. The sub part only orders lines whose group parts are equal.

Two independent masks gate the candidates. A global block bit stops every line. A threshold register, when it is nonzero, stops every line whose group priority is not strictly more urgent than the threshold. Software programs the priorities, the split, the global block bit and the threshold through a single write port. The running handler's group priority comes in as an input. The result is a registered one-cycle take strobe, together with the winning line number and its group priority.

Top module: `irq_arbiter`

## Requirements
- R1: After synchronous reset, `take` is 0, `take_id` is 0 and `take_grp` is 0. Every priority, the split field, the global block bit and the threshold all read as zero.
- R2: A write with `cfg_we`=1 to address i < N loads `cfg_wdata[7:4]` as the priority of line i. Address N loads `cfg_wdata[2:0]` as the split field. Address N+1 loads `cfg_wdata[0]` as the global block bit. Address N+2 loads `cfg_wdata[7:4]` as the threshold. All other data bits are ignored.
- R3: Among the eligible lines, the one with the numerically smallest 4-bit priority wins. This compares the group part first and the sub part second.
- R4: When the full priorities are equal, the lower line number wins.
- R5: For a split value s, the number of sub bits is 0 if s<=3 and s-3 otherwise (so s=7 gives 4 sub bits). The group priority is the priority with those low bits cleared, and this value is reported on `take_grp`.
- R6: `take` rises only if `run_active` is 0 or the winner's group priority is numerically less than `run_grp`. An equal group priority never preempts, whatever the sub part.
- R7: A line is a candidate only while both its pending bit and its enable bit are 1.
- R8: While the global block bit is 1, `take` stays 0 for every input pattern.
- R9: A nonzero threshold T blocks every line whose group priority is >= T. A threshold of zero blocks nothing.
- R10: The outputs are registered. They reflect the inputs and configuration present before the previous rising edge. When `take` is 0, `take_id` and `take_grp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_IRQ+3) | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| irq_pend | input | NUM_IRQ | Pending bit per line |
| irq_en | input | NUM_IRQ | Enable bit per line |
| run_active | input | 1 | A handler is currently running |
| run_grp | input | 4 | Group priority of the running handler |
| take | output | 1 | Take or preempt now |
| take_id | output | $clog2(NUM_IRQ) | Winning line number |
| take_grp | output | 4 | Group priority of the winner |

## Verification
The assertions assume that `run_grp` is meaningful only while `run_active` is high. They also assume that pending and enable bits are plain levels that may change on any cycle, and that configuration writes may land between any two vectors. The stimulus stays inside these assumptions in two ways. It drives every input on the falling edge. It reprograms priorities, split, block bit and threshold only through the write port, and it sweeps all eight split values against mixed pending, enable and running-level patterns.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int PRIO_W = 4;
    localparam int SPLIT_W = 3;
    localparam int REG_W = 8;
    localparam int LOW_UNIMPL = REG_W - PRIO_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SPLIT_W-1:0] split_t;

    typedef struct packed {
        logic  valid;
        prio_t prio;
    } cand_t;

    // Implemented bit b sits at bit b+LOW_UNIMPL of the 8-bit field and
    // belongs to the sub part when that position is at or below the split.
    function automatic prio_t sub_mask(input split_t s);
        prio_t m;
        m = '0;
        for (int b = 0; b < PRIO_W; b++) begin
            if (int'(s) >= b + LOW_UNIMPL) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic prio_t group_of(input prio_t p, input split_t s);
        return p & ~sub_mask(s);
    endfunction

endpackage

// File: rtl/irq_arb_cfg.sv
module irq_arb_cfg
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wdata,
    output prio_t [NUM_IRQ-1:0]       prio_q,
    output split_t                    split_q,
    output logic                      gmask_q,
    output prio_t                     thr_q
);

    localparam int A_SPLIT = NUM_IRQ;
    localparam int A_GMASK = NUM_IRQ + 1;
    localparam int A_THR   = NUM_IRQ + 2;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[i] <= '0;
            end else if (we && addr == ADDR_W'(i)) begin
                prio_q[i] <= wdata[REG_W-1 -: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            split_q <= '0;
            gmask_q <= 1'b0;
            thr_q   <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(A_SPLIT)) split_q <= wdata[SPLIT_W-1:0];
            if (addr == ADDR_W'(A_GMASK)) gmask_q <= wdata[0];
            if (addr == ADDR_W'(A_THR))   thr_q   <= wdata[REG_W-1 -: PRIO_W];
        end
    end

endmodule

// File: rtl/irq_arb_elig.sv
module irq_arb_elig
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0]  pend,
    input  logic [NUM_IRQ-1:0]  en,
    input  prio_t [NUM_IRQ-1:0] prio,
    input  split_t              split,
    input  logic                gmask,
    input  prio_t               thr,
    output logic [NUM_IRQ-1:0]  elig
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        prio_t grp;
        logic  thr_ok;
        always_comb begin
            grp    = group_of(prio[i], split);
            thr_ok = (thr == '0) || (grp < thr);
            elig[i] = pend[i] && en[i] && !gmask && thr_ok;
        end
    end

endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int IDX_W = 3
) (
    input  logic [NUM_IRQ-1:0]  elig,
    input  prio_t [NUM_IRQ-1:0] prio,
    output cand_t               best,
    output logic [IDX_W-1:0]    best_idx
);

    // Ascending scan with a strict compare keeps the lower index on ties.
    always_comb begin
        best.valid = 1'b0;
        best.prio  = '1;
        best_idx   = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!best.valid || prio[i] < best.prio)) begin
                best.valid = 1'b1;
                best.prio  = prio[i];
                best_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int ADDR_W = $clog2(NUM_IRQ + 3)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [7:0]         cfg_wdata,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               run_active,
    input  logic [3:0]         run_grp,
    output logic               take,
    output logic [IDX_W-1:0]   take_id,
    output logic [3:0]         take_grp
);

    prio_t [NUM_IRQ-1:0] prio_q;
    split_t              split_q;
    logic                gmask_q;
    prio_t               thr_q;
    logic [NUM_IRQ-1:0]  elig;
    cand_t               best;
    logic [IDX_W-1:0]    best_idx;
    prio_t               win_grp;
    logic                go;

    irq_arb_cfg #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .prio_q  (prio_q),
        .split_q (split_q),
        .gmask_q (gmask_q),
        .thr_q   (thr_q)
    );

    irq_arb_elig #(.NUM_IRQ(NUM_IRQ)) u_elig (
        .pend  (irq_pend),
        .en    (irq_en),
        .prio  (prio_q),
        .split (split_q),
        .gmask (gmask_q),
        .thr   (thr_q),
        .elig  (elig)
    );

    irq_arb_pick #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
        .elig     (elig),
        .prio     (prio_q),
        .best     (best),
        .best_idx (best_idx)
    );

    always_comb begin
        win_grp = group_of(best.prio, split_q);
        go      = best.valid && (!run_active || win_grp < prio_t'(run_grp));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take     <= 1'b0;
            take_id  <= '0;
            take_grp <= '0;
        end else begin
            take     <= go;
            take_id  <= go ? best_idx : '0;
            take_grp <= go ? win_grp : '0;
        end
    end

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int NUM_IRQ = 8,
    parameter int IDX_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_IRQ-1:0] irq_pend,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic               run_active,
    input logic [3:0]         run_grp,
    input logic               gmask_q,
    input logic [3:0]         thr_q,
    input logic               take,
    input logic [IDX_W-1:0]   take_id,
    input logic [3:0]         take_grp
);

    logic [NUM_IRQ-1:0] live_d;
    logic               ra_d;
    logic [3:0]         rg_d;
    logic               gm_d;
    logic [3:0]         thr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_d <= '0;
            ra_d   <= 1'b0;
            rg_d   <= '0;
            gm_d   <= 1'b0;
            thr_d  <= '0;
        end else begin
            live_d <= irq_pend & irq_en;
            ra_d   <= run_active;
            rg_d   <= run_grp;
            gm_d   <= gmask_q;
            thr_d  <= thr_q;
        end
    end

    a_r6_strict_preempt: assert property (@(posedge clk) disable iff (rst)
        take |-> (!ra_d || take_grp < rg_d));

    a_r7_taken_is_live: assert property (@(posedge clk) disable iff (rst)
        take |-> live_d[take_id]);

    a_r8_global_block: assert property (@(posedge clk) disable iff (rst)
        gm_d |-> !take);

    a_r9_threshold_gate: assert property (@(posedge clk) disable iff (rst)
        take |-> (thr_d == 4'd0 || take_grp < thr_d));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !take |-> (take_id == '0 && take_grp == 4'd0));

endmodule

bind irq_arbiter irq_arbiter_chk #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_pend   (irq_pend),
    .irq_en     (irq_en),
    .run_active (run_active),
    .run_grp    (run_grp),
    .gmask_q    (gmask_q),
    .thr_q      (thr_q),
    .take       (take),
    .take_id    (take_id),
    .take_grp   (take_grp)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;

    localparam int N = 8;
    localparam int IW = 3;
    localparam int AW = 4;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [N-1:0]  irq_pend = '0;
    logic [N-1:0]  irq_en = '0;
    logic          run_active = 1'b0;
    logic [3:0]    run_grp = '0;
    logic          take;
    logic [IW-1:0] take_id;
    logic [3:0]    take_grp;

    int applied = 0;
    int bad = 0;
    bit done = 0;

    int sh_prio [N];
    int sh_split = 0;
    int sh_gmask = 0;
    int sh_thr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arbiter #(.NUM_IRQ(N)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_pend(irq_pend), .irq_en(irq_en),
        .run_active(run_active), .run_grp(run_grp), .take(take),
        .take_id(take_id), .take_grp(take_grp)
    );

    task automatic chk(input string tag, input int act_t, input int act_i, input int act_g,
                       input int exp_t, input int exp_i, input int exp_g);
        applied++;
        if (act_t != exp_t || act_i != exp_i || act_g != exp_g) begin
            bad++;
            $display("FAIL %s: take/id/grp actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, act_t, act_i, act_g, exp_t, exp_i, exp_g);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < N) sh_prio[a] = (d >> 4) & 15;
        else if (a == N) sh_split = d & 7;
        else if (a == N + 1) sh_gmask = d & 1;
        else if (a == N + 2) sh_thr = (d >> 4) & 15;
    endtask

    // Reference model built from the requirement text.
    task automatic model(output int et, output int ei, output int eg);
        int nsub, bp, bi, g;
        nsub = (sh_split <= 3) ? 0 : sh_split - 3;
        bp = 99; bi = -1;
        for (int i = 0; i < N; i++) begin
            g = (sh_prio[i] >> nsub) << nsub;
            if (irq_pend[i] && irq_en[i] && sh_gmask == 0 &&
                (sh_thr == 0 || g < sh_thr) && sh_prio[i] < bp) begin
                bp = sh_prio[i]; bi = i;
            end
        end
        et = 0; ei = 0; eg = 0;
        if (bi >= 0) begin
            g = (bp >> nsub) << nsub;
            if (!run_active || g < int'(run_grp)) begin
                et = 1; ei = bi; eg = g;
            end
        end
    endtask

    task automatic vec(input string tag, input int p, input int e, input int ra, input int rg);
        int et, ei, eg;
        @(negedge clk);
        irq_pend = N'(p); irq_en = N'(e); run_active = ra[0]; run_grp = 4'(rg);
        model(et, ei, eg);
        @(negedge clk);
        chk(tag, int'(take), int'(take_id), int'(take_grp), et, ei, eg);
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) sh_prio[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset outputs
        chk("R1 reset outputs", int'(take), int'(take_id), int'(take_grp), 0, 0, 0);
        // R1 R4: all priorities zero after reset, lowest line wins
        vec("R1 R4 zero config", 'hA4, 'hFF, 0, 0);
        chk("R1 zero config id", int'(take_id), 0, 0, 2, 0, 0);
        // R2: upper nibble loaded, lower ignored
        wr(0, 'h9F); wr(1, 'h9F); wr(2, 'h5A); wr(5, 'h4F); wr(6, 'h4F);
        for (int i = 3; i < N; i++) if (i != 5 && i != 6) wr(i, 'hF0);
        vec("R2 field position", 'h24, 'hFF, 0, 0);
        chk("R2 winner line5", int'(take_id), int'(take_grp), 0, 5, 4, 0);
        // R4: equal priority, lower number wins
        vec("R4 tie lower index", 'h60, 'hFF, 0, 0);
        // R7: pending without enable ignored
        vec("R7 disabled line", 'h20, 'hDF, 0, 0);
        vec("R7 enable without pend", 'h00, 'hFF, 0, 0);
        // R5 R6: split 5 gives two sub bits
        wr(0, 'h60); wr(1, 'h50); wr(N, 'h05);
        vec("R6 equal group no preempt", 'h03, 'h03, 1, 4);
        vec("R3 R5 sub decides", 'h03, 'h03, 1, 8);
        vec("R6 idle takes", 'h03, 'h03, 0, 0);
        // R5: split 7 gives group 0 always; running level 0 blocks
        wr(N, 'h07);
        vec("R5 all sub", 'h03, 'h03, 1, 0);
        vec("R5 all sub idle", 'h03, 'h03, 0, 0);
        wr(N, 'h00);
        // R8: global block
        wr(N + 1, 'h01);
        vec("R8 blocked", 'hFF, 'hFF, 0, 0);
        wr(N + 1, 'hFE);
        vec("R8 released", 'hFF, 'hFF, 0, 0);
        // R9: threshold
        wr(2, 'h20); wr(N + 2, 'h4F);
        vec("R9 line5 at threshold blocked", 'h20, 'hFF, 0, 0);
        vec("R9 more urgent passes", 'h24, 'hFF, 0, 0);
        wr(N + 2, 'h00);
        vec("R9 zero disables", 'h20, 'hFF, 0, 0);
        // R10: output clears one cycle after candidates vanish
        vec("R10 idle zero", 'h00, 'hFF, 0, 0);

        // Sweep: every split with mixed masks and running levels.
        for (int ep = 0; ep < 64; ep++) begin
            for (int i = 0; i < N; i++) wr(i, int'($urandom_range(0, 255)));
            wr(N, ep % 8);
            wr(N + 1, (ep % 7 == 3) ? 1 : 0);
            wr(N + 2, (ep % 3 == 0) ? 0 : int'($urandom_range(0, 255)));
            for (int v = 0; v < 40; v++) begin
                vec("R3 R4 R5 R6 R7 R8 R9 sweep",
                    int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule